// File: doc/BRIEF.md
# Reconfigurable Runtime Security Monitor

This block sits beside a functional unit and watches a few of its signals while the chip runs in the field. A small write port loads the configuration. It picks one check at a time: a restricted address window, entry into test or debug mode during field operation, an ordering rule between two chosen signals, or a self-test of the detector. When the active check sees a violation, the block raises an alert. It can also force three pass-through functional signals into a safe value: the unit's clock enable is held low, its active-low reset is held asserted, or a memory wipe is requested.

Each overridden signal passes through a single multiplexer, so the monitor adds one mux delay on that path. A new configuration can be written at any time. Each write restarts the check engine from idle, so that no alert comes from a half-loaded setting. Countermeasures stay latched until a clear command or a reset.

The check engine is a state machine with five states:
- `S_IDLE` is the state after reset or after any configuration write.
- `S_WATCH` is the state where the active check is evaluated.
- `S_ARMED` is used by the ordering check after its first signal has been seen.
- `S_TRIP` is the single cycle that follows a detection.
- `S_PARK` is a quiet state the engine enters after a self-test has fired.

Its transitions are:
- idle to watch, on the first cycle with a check kind other than off;
- watch to armed, when the first ordering signal is seen;
- armed to watch, when the second ordering signal consumes the arming;
- watch to trip, on a violation;
- trip back to watch, or trip to park in self-test;
- any state to idle, on a configuration write.

Top module: `sec_watch_top`

Configuration registers are selected by `cfg_addr`:

| Address | Contents |
|---|---|
| 0 | Control word. Bits [2:0] hold the check kind. Bits [5:3] hold the countermeasure mask: bit 3 gates the clock enable, bit 4 holds the reset, bit 5 requests the wipe. Bits [8:6] select the first ordering signal and bits [11:9] select the second. |
| 1 | Inclusive lower bound of the address window. |
| 2 | Inclusive upper bound of the address window. |
| 3 | Clear command. A write with bit 0 set performs the clear. |

The check kind codes are:
- 0: off
- 1: address window
- 2: mode entry
- 3: ordering
- 4: self-test
- 5, 6 and 7: treated as off

## Requirements
- R1: After reset, `alert_pulse`, `alert_level` and `alert_code` are 0, the check kind is off, and each `blk_*_o` equals its `blk_*_i`.
- R2: With kind 1, an access with `mon_valid`=1 and `lo <= mon_addr <= hi` (both bounds inclusive) is a violation with `alert_code`=1. An access outside the window, or with `mon_valid`=0, is not a violation.
- R3: With kind 2, a rising edge of (`test_en` OR `debug_en`) while `in_field`=1 is a violation with code 2. Such a rise while `in_field`=0 is not a violation, and a request that stays high does not fire again.
- R4: With kind 3, the selected second signal asserted without an unconsumed earlier assertion of the selected first signal is a violation with code 3. Each assertion of the first signal permits one later assertion of the second.
- R5: `alert_pulse` is high for exactly one cycle per violation. `alert_level` stays high until a clear.
- R6: On a violation, each countermeasure whose mask bit is set latches. A latched clock gate drives `blk_clk_en_o` to 0, a latched reset hold drives `blk_rst_n_o` to 0, and a latched wipe drives `blk_wipe_o` to 1, whatever the inputs do. Channels whose mask bit is clear keep passing their input through.
- R7: A channel that is not latched forwards its input to its output in the same cycle, with no register on the path.
- R8: A configuration write returns the engine to idle. Stimulus in the cycle right after the write is not evaluated. Evaluation starts on the second cycle after the write.
- R9: A clear write (address 3, bit 0 set) releases all latched countermeasures and returns `alert_level` and `alert_code` to 0.
- R10: With kind 4, the detector is fed the window's lower bound as a known access. It fires once with code 4, latches no countermeasure, and then stays quiet until the next configuration write.
- R11: With check kind 0, 5, 6 or 7, no stimulus raises an alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | DW (16) | Configuration write data |
| mon_valid | input | 1 | Monitored access is valid |
| mon_addr | input | AW (16) | Monitored access address |
| mon_sig | input | SW (8) | Monitored signal group for the ordering check |
| in_field | input | 1 | Chip is in normal field operation |
| test_en | input | 1 | Test mode request |
| debug_en | input | 1 | Debug mode request |
| blk_clk_en_i | input | 1 | Functional clock enable, incoming |
| blk_rst_n_i | input | 1 | Functional active-low reset, incoming |
| blk_wipe_i | input | 1 | Functional memory wipe request, incoming |
| blk_clk_en_o | output | 1 | Clock enable after override |
| blk_rst_n_o | output | 1 | Reset after override |
| blk_wipe_o | output | 1 | Wipe request after override |
| alert_pulse | output | 1 | One-cycle alert |
| alert_level | output | 1 | Sticky alert flag |
| alert_code | output | 3 | Kind of the latest check that fired |

## Verification
A stimulus applied before a clock edge is evaluated at that edge. The alert pulse, sticky flag, code and latched overrides all become visible right after that edge, and the pulse drops one cycle later. A configuration or clear write lands at its edge, and the stimulus that first counts is the one sampled two edges after the write. The override multiplexers themselves respond with no clock at all. The bench drives inputs at falling edges and reads results at the next falling edge, one rising edge later. It uses a short settle delay only for the combinational pass-through checks.

// File: rtl/sec_watch_pkg.sv
package sec_watch_pkg;

    typedef enum logic [2:0] {
        CK_OFF  = 3'd0,
        CK_WIN  = 3'd1,
        CK_MODE = 3'd2,
        CK_SEQ  = 3'd3,
        CK_SELF = 3'd4
    } chk_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WATCH,
        S_ARMED,
        S_TRIP,
        S_PARK
    } st_e;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_LO   = 2'd1;
    localparam logic [1:0] RA_HI   = 2'd2;
    localparam logic [1:0] RA_CLR  = 2'd3;

    localparam int NOVR    = 3;
    localparam int OV_CLK  = 0;
    localparam int OV_RST  = 1;
    localparam int OV_WIPE = 2;

    // forced value per override channel: clock enable 0, reset 0, wipe 1
    localparam logic [NOVR-1:0] FORCE_VAL = 3'b100;

    localparam int KIND_W  = 3;
    localparam int MSK_LSB = KIND_W;
    localparam int SA_LSB  = MSK_LSB + NOVR;

endpackage

// File: rtl/sec_watch_cfg.sv
module sec_watch_cfg
    import sec_watch_pkg::*;
#(
    parameter int AW   = 16,
    parameter int SW   = 8,
    parameter int DW   = 16,
    parameter int SELW = $clog2(SW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [1:0]      addr,
    input  logic [DW-1:0]   wdata,
    output chk_e            kind,
    output logic [NOVR-1:0] mask,
    output logic [SELW-1:0] sel_a,
    output logic [SELW-1:0] sel_b,
    output logic [AW-1:0]   win_lo,
    output logic [AW-1:0]   win_hi,
    output logic            cfg_wr,
    output logic            clr
);
    localparam int SB_LSB = SA_LSB + SELW;

    chk_e            kind_q;
    logic [NOVR-1:0] mask_q;
    logic [SELW-1:0] sa_q, sb_q;
    logic [AW-1:0]   lo_q, hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= CK_OFF;
            mask_q <= '0;
            sa_q   <= '0;
            sb_q   <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else if (we) begin
            unique case (addr)
                RA_CTRL: begin
                    kind_q <= (wdata[KIND_W-1:0] <= 3'd4) ? chk_e'(wdata[KIND_W-1:0]) : CK_OFF;
                    mask_q <= wdata[MSK_LSB +: NOVR];
                    sa_q   <= wdata[SA_LSB +: SELW];
                    sb_q   <= wdata[SB_LSB +: SELW];
                end
                RA_LO:   lo_q <= wdata[AW-1:0];
                RA_HI:   hi_q <= wdata[AW-1:0];
                default: ;
            endcase
        end
    end

    assign kind   = kind_q;
    assign mask   = mask_q;
    assign sel_a  = sa_q;
    assign sel_b  = sb_q;
    assign win_lo = lo_q;
    assign win_hi = hi_q;
    assign cfg_wr = we;
    assign clr    = we && (addr == RA_CLR) && wdata[0];

endmodule

// File: rtl/sec_watch_eval.sv
module sec_watch_eval #(
    parameter int AW   = 16,
    parameter int SW   = 8,
    parameter int SELW = $clog2(SW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mon_valid,
    input  logic [AW-1:0]   mon_addr,
    input  logic [SW-1:0]   mon_sig,
    input  logic [SELW-1:0] sel_a,
    input  logic [SELW-1:0] sel_b,
    input  logic [AW-1:0]   win_lo,
    input  logic [AW-1:0]   win_hi,
    input  logic            in_field,
    input  logic            test_en,
    input  logic            debug_en,
    output logic            win_hit,
    output logic            mode_entry,
    output logic            sig_a,
    output logic            sig_b,
    output logic            self_ok
);
    function automatic logic inside_win(input logic [AW-1:0] a,
                                        input logic [AW-1:0] lo,
                                        input logic [AW-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    logic req, req_q;
    assign req = test_en | debug_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req;
    end

    assign win_hit    = mon_valid && inside_win(mon_addr, win_lo, win_hi);
    assign self_ok    = inside_win(win_lo, win_lo, win_hi);
    assign mode_entry = in_field && req && !req_q;
    assign sig_a      = mon_sig[sel_a];
    assign sig_b      = mon_sig[sel_b];

    // R3: an entry is an edge, never two cycles in a row
    assert_entry_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_entry |=> !mode_entry);

endmodule

// File: rtl/sec_watch_fsm.sv
module sec_watch_fsm
    import sec_watch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       clr,
    input  chk_e       kind,
    input  logic       win_hit,
    input  logic       mode_entry,
    input  logic       sig_a,
    input  logic       sig_b,
    input  logic       self_ok,
    output logic       alert_pulse,
    output logic       alert_level,
    output logic [2:0] alert_code,
    output logic       fire_ovr
);
    st_e        st_q, st_d;
    logic       viol;
    logic       level_q;
    logic [2:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        viol = 1'b0;
        unique case (st_q)
            S_IDLE:  st_d = (kind == CK_OFF) ? S_IDLE : S_WATCH;
            S_WATCH: begin
                unique case (kind)
                    CK_WIN:  viol = win_hit;
                    CK_MODE: viol = mode_entry;
                    CK_SEQ: begin
                        viol = sig_b;
                        if (!sig_b && sig_a) st_d = S_ARMED;
                    end
                    CK_SELF: viol = self_ok;
                    default: st_d = S_IDLE;
                endcase
            end
            S_ARMED: if (sig_b) st_d = S_WATCH;
            S_TRIP:  st_d = (kind == CK_SELF) ? S_PARK : S_WATCH;
            S_PARK:  st_d = S_PARK;
            default: st_d = S_IDLE;
        endcase
        if (viol) st_d = S_TRIP;
        if (cfg_wr) begin
            st_d = S_IDLE;
            viol = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            code_q  <= 3'd0;
        end else if (clr) begin
            level_q <= 1'b0;
            code_q  <= 3'd0;
        end else if (viol) begin
            level_q <= 1'b1;
            code_q  <= kind;
        end
    end

    assign alert_pulse = (st_q == S_TRIP);
    assign alert_level = level_q;
    assign alert_code  = code_q;
    assign fire_ovr    = viol && (kind != CK_SELF);

    assert_pulse_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alert_pulse |=> !alert_pulse);

    assert_level_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_level && !clr) |=> alert_level);

    assert_pulse_with_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alert_pulse |-> alert_level);

    assert_cfg_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !alert_pulse ##1 !alert_pulse);

    assert_clear_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!alert_level && alert_code == 3'd0));

endmodule

// File: rtl/sec_watch_ovr.sv
module sec_watch_ovr
    import sec_watch_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            fire,
    input  logic [NOVR-1:0] mask,
    input  logic [NOVR-1:0] fn_in,
    output logic [NOVR-1:0] fn_out
);
    logic [NOVR-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hold_q <= '0;
        else if (clr)  hold_q <= '0;
        else if (fire) hold_q <= hold_q | mask;
    end

    for (genvar gi = 0; gi < NOVR; gi++) begin : g_mux
        assign fn_out[gi] = hold_q[gi] ? FORCE_VAL[gi] : fn_in[gi];

        assert_hold_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_q[gi] && !clr) |=> hold_q[gi]);
    end

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fn_out == fn_in));

endmodule

// File: rtl/sec_watch_top.sv
module sec_watch_top
    import sec_watch_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          mon_valid,
    input  logic [AW-1:0] mon_addr,
    input  logic [SW-1:0] mon_sig,
    input  logic          in_field,
    input  logic          test_en,
    input  logic          debug_en,
    input  logic          blk_clk_en_i,
    input  logic          blk_rst_n_i,
    input  logic          blk_wipe_i,
    output logic          blk_clk_en_o,
    output logic          blk_rst_n_o,
    output logic          blk_wipe_o,
    output logic          alert_pulse,
    output logic          alert_level,
    output logic [2:0]    alert_code
);
    localparam int SELW = $clog2(SW);

    chk_e            kind;
    logic [NOVR-1:0] mask;
    logic [SELW-1:0] sel_a, sel_b;
    logic [AW-1:0]   win_lo, win_hi;
    logic            cfg_wr, clr;
    logic            win_hit, mode_entry, sig_a, sig_b, self_ok;
    logic            fire_ovr;
    logic [NOVR-1:0] fn_in, fn_out;

    sec_watch_cfg #(.AW(AW), .SW(SW), .DW(DW), .SELW(SELW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .kind(kind), .mask(mask), .sel_a(sel_a), .sel_b(sel_b),
        .win_lo(win_lo), .win_hi(win_hi), .cfg_wr(cfg_wr), .clr(clr)
    );

    sec_watch_eval #(.AW(AW), .SW(SW), .SELW(SELW)) u_eval (
        .clk(clk), .rst_n(rst_n), .mon_valid(mon_valid), .mon_addr(mon_addr),
        .mon_sig(mon_sig), .sel_a(sel_a), .sel_b(sel_b), .win_lo(win_lo), .win_hi(win_hi),
        .in_field(in_field), .test_en(test_en), .debug_en(debug_en),
        .win_hit(win_hit), .mode_entry(mode_entry), .sig_a(sig_a), .sig_b(sig_b),
        .self_ok(self_ok)
    );

    sec_watch_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .clr(clr), .kind(kind),
        .win_hit(win_hit), .mode_entry(mode_entry), .sig_a(sig_a), .sig_b(sig_b),
        .self_ok(self_ok), .alert_pulse(alert_pulse), .alert_level(alert_level),
        .alert_code(alert_code), .fire_ovr(fire_ovr)
    );

    assign fn_in[OV_CLK]  = blk_clk_en_i;
    assign fn_in[OV_RST]  = blk_rst_n_i;
    assign fn_in[OV_WIPE] = blk_wipe_i;

    sec_watch_ovr u_ovr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fire(fire_ovr), .mask(mask),
        .fn_in(fn_in), .fn_out(fn_out)
    );

    assign blk_clk_en_o = fn_out[OV_CLK];
    assign blk_rst_n_o  = fn_out[OV_RST];
    assign blk_wipe_o   = fn_out[OV_WIPE];

    // R10: a self-test detection never moves an override
    assert_self_no_ovr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CK_SELF && !cfg_wr && fn_out == fn_in) |=> (fn_out == fn_in) || $changed(fn_in));

endmodule

// File: tb/sim_sec_watch_top.sv
`timescale 1ns/1ps
module sim_sec_watch_top;
    localparam int AW = 16;
    localparam int SW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [1:0]    cfg_addr;
    logic [DW-1:0] cfg_wdata;
    logic          mon_valid;
    logic [AW-1:0] mon_addr;
    logic [SW-1:0] mon_sig;
    logic          in_field, test_en, debug_en;
    logic          blk_clk_en_i, blk_rst_n_i, blk_wipe_i;
    logic          blk_clk_en_o, blk_rst_n_o, blk_wipe_o;
    logic          alert_pulse, alert_level;
    logic [2:0]    alert_code;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    sec_watch_top #(.AW(AW), .SW(SW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mon_valid(mon_valid), .mon_addr(mon_addr), .mon_sig(mon_sig),
        .in_field(in_field), .test_en(test_en), .debug_en(debug_en),
        .blk_clk_en_i(blk_clk_en_i), .blk_rst_n_i(blk_rst_n_i), .blk_wipe_i(blk_wipe_i),
        .blk_clk_en_o(blk_clk_en_o), .blk_rst_n_o(blk_rst_n_o), .blk_wipe_o(blk_wipe_o),
        .alert_pulse(alert_pulse), .alert_level(alert_level), .alert_code(alert_code)
    );

    // {expected trip, valid, address}; window is 0x0100..0x01FF
    localparam logic [17:0] WVEC [6] = '{
        {1'b0, 1'b1, 16'h00FF},
        {1'b1, 1'b1, 16'h0100},
        {1'b1, 1'b1, 16'h01FF},
        {1'b0, 1'b1, 16'h0200},
        {1'b0, 1'b0, 16'h0150},
        {1'b1, 1'b1, 16'h0180}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [15:0] ctrl(input logic [2:0] k, input logic [2:0] m,
                                         input logic [2:0] sa, input logic [2:0] sb);
        return {4'b0, sb, sa, m, k};
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        mon_valid = 1'b0; mon_addr = '0; mon_sig = '0;
        in_field = 1'b0; test_en = 1'b0; debug_en = 1'b0;
        blk_clk_en_i = 1'b1; blk_rst_n_i = 1'b1; blk_wipe_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 pulse", alert_pulse, 0);
        check("R1 level", alert_level, 0);
        check("R1 code", alert_code, 0);
        check("R1 clk_en pass", blk_clk_en_o, 1);
        check("R1 rst_n pass", blk_rst_n_o, 1);
        check("R1 wipe pass", blk_wipe_o, 0);

        // R11 kind off after reset: an access at the 0..0 window does nothing
        @(negedge clk); mon_valid = 1'b1; mon_addr = '0;
        @(negedge clk); mon_valid = 1'b0;
        check("R11 off no pulse", alert_pulse, 0);
        @(negedge clk);
        check("R11 off no level", alert_level, 0);

        // R7 combinational pass-through
        blk_clk_en_i = 1'b0; blk_wipe_i = 1'b1; blk_rst_n_i = 1'b0; #1;
        check("R7 clk_en follows", blk_clk_en_o, 0);
        check("R7 wipe follows", blk_wipe_o, 1);
        check("R7 rst_n follows", blk_rst_n_o, 0);
        blk_clk_en_i = 1'b1; blk_wipe_i = 1'b0; blk_rst_n_i = 1'b1;

        // R2 window table, no countermeasures
        cfg_write(2'd1, 16'h0100);
        cfg_write(2'd2, 16'h01FF);
        cfg_write(2'd0, ctrl(3'd1, 3'b000, 3'd0, 3'd0));
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            mon_valid = WVEC[i][16]; mon_addr = WVEC[i][15:0];
            @(negedge clk);
            mon_valid = 1'b0;
            check($sformatf("R2 window vector %0d pulse", i), alert_pulse, WVEC[i][17]);
            if (WVEC[i][17]) check("R2 window code", alert_code, 1);
            @(negedge clk);
            check("R5 pulse lasts one cycle", alert_pulse, 0);
        end
        check("R5 level stays", alert_level, 1);
        check("R6 unmasked clk_en", blk_clk_en_o, 1);
        check("R6 unmasked wipe", blk_wipe_o, 0);

        // R9 clear
        cfg_write(2'd3, 16'h0001);
        check("R9 level cleared", alert_level, 0);
        check("R9 code cleared", alert_code, 0);

        // R3 mode entry, mask clock gate and wipe
        cfg_write(2'd0, ctrl(3'd2, 3'b101, 3'd0, 3'd0));
        @(negedge clk); test_en = 1'b1;
        @(negedge clk);
        check("R3 out of field no pulse", alert_pulse, 0);
        test_en = 1'b0;
        @(negedge clk); in_field = 1'b1; debug_en = 1'b1;
        @(negedge clk);
        check("R3 entry pulse", alert_pulse, 1);
        check("R3 entry code", alert_code, 2);
        check("R6 clk_en forced", blk_clk_en_o, 0);
        check("R6 wipe forced", blk_wipe_o, 1);
        check("R6 rst_n unmasked", blk_rst_n_o, 1);
        @(negedge clk);
        @(negedge clk);
        check("R3 held request no refire", alert_pulse, 0);
        blk_clk_en_i = 1'b0; #1; blk_clk_en_i = 1'b1; #1;
        check("R6 clk_en stays forced", blk_clk_en_o, 0);
        check("R5 level after entry", alert_level, 1);

        cfg_write(2'd3, 16'h0001);
        check("R9 clk_en released", blk_clk_en_o, 1);
        check("R9 wipe released", blk_wipe_o, 0);
        debug_en = 1'b0; in_field = 1'b0;

        // R4 ordering: first signal bit 2, second bit 5, mask reset hold
        cfg_write(2'd0, ctrl(3'd3, 3'b010, 3'd2, 3'd5));
        @(negedge clk); mon_sig = 8'h20;
        @(negedge clk); mon_sig = 8'h00;
        check("R4 second without first", alert_pulse, 1);
        check("R4 code", alert_code, 3);
        check("R6 rst_n forced", blk_rst_n_o, 0);
        @(negedge clk);
        cfg_write(2'd3, 16'h0001);
        check("R9 rst_n released", blk_rst_n_o, 1);
        @(negedge clk); mon_sig = 8'h04;
        @(negedge clk); mon_sig = 8'h00;
        @(negedge clk); mon_sig = 8'h20;
        @(negedge clk); mon_sig = 8'h00;
        check("R4 legal order no pulse", alert_pulse, 0);
        check("R4 legal order no level", alert_level, 0);
        @(negedge clk); mon_sig = 8'h20;
        @(negedge clk); mon_sig = 8'h00;
        check("R4 arming consumed", alert_pulse, 1);
        @(negedge clk);

        // R8 stimulus right after a write is not evaluated
        @(negedge clk); cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 16'h0001;
        @(negedge clk); cfg_we = 1'b0; mon_sig = 8'h20;
        @(negedge clk); mon_sig = 8'h00;
        check("R8 ignored after write", alert_pulse, 0);
        @(negedge clk);
        check("R8 no pulse later", alert_pulse, 0);
        check("R8 no level", alert_level, 0);

        // R11 reserved kind code 5 behaves as off
        cfg_write(2'd0, ctrl(3'd5, 3'b111, 3'd2, 3'd5));
        @(negedge clk); mon_sig = 8'h20; mon_valid = 1'b1; mon_addr = 16'h0100;
        @(negedge clk); mon_sig = 8'h00; mon_valid = 1'b0;
        check("R11 reserved no pulse", alert_pulse, 0);
        @(negedge clk);
        check("R11 reserved no level", alert_level, 0);
        check("R11 reserved no override", blk_rst_n_o, 1);

        // R10 self-test
        cfg_write(2'd0, ctrl(3'd4, 3'b111, 3'd0, 3'd0));
        @(negedge clk);
        check("R10 self-test pulse", alert_pulse, 1);
        check("R10 self-test code", alert_code, 4);
        check("R10 no clk gate", blk_clk_en_o, 1);
        check("R10 no reset hold", blk_rst_n_o, 1);
        check("R10 no wipe", blk_wipe_o, 0);
        @(negedge clk);
        check("R10 single pulse", alert_pulse, 0);
        @(negedge clk);
        check("R10 parked quiet", alert_pulse, 0);
        check("R10 level set", alert_level, 1);

        finish_run();
    end
endmodule